// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to sixty-four external interrupt requests in two banks of thirty-two. It passes each request through a two-flop synchronizer. For every source it then keeps a pending bit. That bit follows the input while the source is in a level mode. In an edge mode it latches the chosen transition. Each source has a programmable priority level held in a byte lane. Among the sources that are pending and that pass the global enable and the level threshold, the block picks the highest level and drives one interrupt line to the processor. A status word reports which source won.

Software sets up the block through a small synchronous register port. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. A handler reads the status word, serves the reported source and, for edge sources, sends an indexed clear command. Source number 0 is reserved and never wins.

Word addresses: 0 control, 1 threshold, 2 status, 4 + bank edge clear, 8 + 2·bank + k trigger mode, 16 + 8·bank + k priority level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source has a 2-bit trigger mode. 00 is active-low level, 01 is active-high level, 10 is falling edge and 11 is rising edge. An edge source becomes pending only on its selected transition.
- R2: A source whose level is 0 is never delivered. Levels are compared as full unsigned fields.
- R3: Level word k of bank b holds four byte lanes. Lane 0 holds local source 2k, lane 1 holds 2k+1, lane 2 holds 2k+16 and lane 3 holds 2k+17. Reads return the stored bytes.
- R4: Mode word k of bank b (k = local bit 3) holds local source L in bits [2p+1:2p], where p = 8·L[4] + L[2:0]. Reads return the stored fields.
- R5: The edge clear word for bank b clears local source L[3:0] of the lower half when bit 8 is set and bits 3:0 give the index. The same fields shifted up by 16 (bit 24, bits 19:16) address the upper half. Without the enable bit, or with a different index, nothing is cleared.
- R6: Control bit 0 is the global enable. While it is 0, `irq_o` is low and the status word reads empty.
- R7: A source is delivered only if its level is strictly greater than the threshold register.
- R8: The status word reads 0x0001_0000 when nothing qualifies. Otherwise bit 16 is 0 and bits 5:0 give the winning global source number (bank·32 + local). All other bits are 0.
- R9: Source 0 is never reported, whatever its input, mode or level.
- R10: The highest level wins. On equal levels the lowest source number wins.
- R11: An edge event stays pending until it is cleared. A level source is pending only while its synchronized input is active.
- R12: A change on `irq_in` shows on `irq_o` and in the status word after the third rising clock edge. Register writes act on the outputs right after the writing edge.
- R13: After reset the enable and the threshold are 0, all modes are 00, every level is 4, `irq_o` is low and status reads 0x0001_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq_in | input | NUM_BANKS·32 | External interrupt requests |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are known and stable around each rising edge, and that `irq_in` may be asynchronous but never X. The bench drives every input on the falling edge only, so this always holds. The edge-hold property also assumes that a clear and a new event on the same source in the same cycle end with the event latched. The stimulus avoids that coincidence, so the model and the design never disagree on it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int BANK_SRCS      = 32;
   localparam int HALF_SRCS      = 16;
   localparam int REG_W          = 32;
   localparam int A_CTRL         = 0;
   localparam int A_THR          = 1;
   localparam int A_STAT         = 2;
   localparam int A_ECLR         = 4;
   localparam int A_MODE         = 8;
   localparam int A_LVL          = 16;
   localparam int STAT_EMPTY_BIT = 16;
   localparam int ECLR_EN_BIT    = 8;

   typedef enum logic [1:0] {
      TRG_LOW  = 2'b00,
      TRG_HIGH = 2'b01,
      TRG_FALL = 2'b10,
      TRG_RISE = 2'b11
   } trig_e;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
   import prio_irq_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int NSRC      = 64,
   parameter int LVL_W     = 8,
   parameter int DEF_LVL   = 4,
   parameter int ADDR_W    = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [REG_W-1:0]            wdata,
   output logic                        en_o,
   output logic [LVL_W-1:0]            thr_o,
   output trig_e [NSRC-1:0]            mode_o,
   output logic [NSRC-1:0][LVL_W-1:0]  lvl_o,
   output logic [NSRC-1:0]             clr_o,
   output logic [REG_W-1:0]            cfg_rdata
);
   logic [REG_W-1:0] rd_part [NSRC];

   if (NSRC != NUM_BANKS * BANK_SRCS) begin : g_bad_nsrc
      $error("NSRC must equal NUM_BANKS * BANK_SRCS");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= 1'b0;
         thr_o <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_W'(A_CTRL)) en_o  <= wdata[0];
         if (addr == ADDR_W'(A_THR))  thr_o <= wdata[LVL_W-1:0];
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int LOC   = s % BANK_SRCS;
      localparam int BNK   = s / BANK_SRCS;
      localparam int HALF  = LOC / HALF_SRCS;
      localparam int LADDR = A_LVL + BNK * 8 + (LOC % HALF_SRCS) / 2;
      localparam int LLANE = HALF * 2 + LOC % 2;
      localparam int MADDR = A_MODE + BNK * 2 + (LOC % HALF_SRCS) / 8;
      localparam int MPOS  = (HALF * 8 + LOC % 8) * 2;
      localparam int EADDR = A_ECLR + BNK;
      localparam int EPOS  = HALF * HALF_SRCS;

      logic [LVL_W-1:0] lvl_q;
      trig_e            mode_q;
      logic             lvl_sel, mode_sel;

      assign lvl_sel  = (addr == ADDR_W'(LADDR));
      assign mode_sel = (addr == ADDR_W'(MADDR));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q  <= LVL_W'(DEF_LVL);
            mode_q <= TRG_LOW;
         end else if (wr_en) begin
            if (lvl_sel)  lvl_q  <= wdata[LLANE*8 +: LVL_W];
            if (mode_sel) mode_q <= trig_e'(wdata[MPOS +: 2]);
         end
      end

      assign lvl_o[s]  = lvl_q;
      assign mode_o[s] = mode_q;
      assign clr_o[s]  = wr_en && (addr == ADDR_W'(EADDR))
                         && wdata[EPOS + ECLR_EN_BIT]
                         && (wdata[EPOS +: 4] == 4'(LOC % HALF_SRCS));
      assign rd_part[s] = (lvl_sel  ? (REG_W'(lvl_q)  << (LLANE * 8)) : '0)
                        | (mode_sel ? (REG_W'(mode_q) << MPOS)        : '0);
   end

   always_comb begin
      cfg_rdata = '0;
      if (addr == ADDR_W'(A_CTRL)) cfg_rdata[0] = en_o;
      if (addr == ADDR_W'(A_THR))  cfg_rdata[LVL_W-1:0] = thr_o;
      for (int s = 0; s < NSRC; s++) cfg_rdata = cfg_rdata | rd_part[s];
   end

   // R7
   thr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_THR)) |=> (thr_o == $past(wdata[LVL_W-1:0])));
endmodule

// File: rtl/prio_irq_srcs.sv
module prio_irq_srcs
   import prio_irq_pkg::*;
#(
   parameter int NSRC        = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  irq_in,
   input  trig_e [NSRC-1:0] mode,
   input  logic [NSRC-1:0]  clr,
   output logic [NSRC-1:0]  pend
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [SYNC_STAGES:0] sh;
      logic cur, prev, is_edge, active, event_hit, pend_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[SYNC_STAGES-1:0], irq_in[s]};
      end

      assign cur       = sh[SYNC_STAGES-1];
      assign prev      = sh[SYNC_STAGES];
      assign is_edge   = (mode[s] == TRG_FALL) || (mode[s] == TRG_RISE);
      assign active    = (mode[s] == TRG_HIGH) ? cur : !cur;
      assign event_hit = (mode[s] == TRG_RISE) ? (cur && !prev) : (!cur && prev);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend_q <= 1'b0;
         else if (is_edge) pend_q <= (pend_q && !clr[s]) || event_hit;
         else              pend_q <= active;
      end

      assign pend[s] = pend_q;

      // R11
      edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q && is_edge && !clr[s]) |=> pend_q);
   end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
   parameter int NSRC     = 64,
   parameter int LVL_W    = 8,
   parameter int IDX_W    = 6,
   parameter bit TIE_LOW  = 1'b1
) (
   input  logic [NSRC-1:0]             req,
   input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
   output logic                        valid,
   output logic [IDX_W-1:0]            idx
);
   logic [LVL_W-1:0] best;

   if (TIE_LOW) begin : g_tie_low
      always_comb begin
         valid = 1'b0;
         idx   = '0;
         best  = '0;
         for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (lvl[s] > best)) begin
               valid = 1'b1;
               idx   = IDX_W'(s);
               best  = lvl[s];
            end
         end
      end
   end else begin : g_tie_high
      always_comb begin
         valid = 1'b0;
         idx   = '0;
         best  = '0;
         for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (lvl[s] >= best) && (lvl[s] != '0)) begin
               valid = 1'b1;
               idx   = IDX_W'(s);
               best  = lvl[s];
            end
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int LVL_W       = 8,
   parameter int DEF_LVL     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [31:0]                     wdata,
   output logic [31:0]                     rdata,
   input  logic [NUM_BANKS*BANK_SRCS-1:0]  irq_in,
   output logic                            irq_o
);
   localparam int NSRC  = NUM_BANKS * BANK_SRCS;
   localparam int IDX_W = $clog2(NSRC);

   if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
      $error("NUM_BANKS must be 1 or 2");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must fit a byte lane");
   end
   if (DEF_LVL >= (1 << LVL_W)) begin : g_bad_def
      $error("DEF_LVL does not fit LVL_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic                        en;
   logic [LVL_W-1:0]            thr;
   trig_e [NSRC-1:0]            mode_w;
   logic [NSRC-1:0][LVL_W-1:0]  lvl_w;
   logic [NSRC-1:0]             clr_w, pend_w, qual;
   logic [REG_W-1:0]            cfg_rdata, stat;
   logic                        win_vld;
   logic [IDX_W-1:0]            win;

   prio_irq_regs #(
      .NUM_BANKS(NUM_BANKS), .NSRC(NSRC), .LVL_W(LVL_W),
      .DEF_LVL(DEF_LVL), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .en_o(en), .thr_o(thr), .mode_o(mode_w), .lvl_o(lvl_w),
      .clr_o(clr_w), .cfg_rdata(cfg_rdata)
   );

   prio_irq_srcs #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_srcs (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mode(mode_w),
      .clr(clr_w), .pend(pend_w)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_qual
      localparam bit LIVE = (s != 0);
      assign qual[s] = LIVE && en && pend_w[s]
                       && (lvl_w[s] != '0) && (lvl_w[s] > thr);
   end

   prio_irq_arb #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W), .TIE_LOW(1'b1)) u_arb (
      .req(qual), .lvl(lvl_w), .valid(win_vld), .idx(win)
   );

   always_comb begin
      stat = '0;
      stat[STAT_EMPTY_BIT] = !win_vld;
      if (win_vld) stat[IDX_W-1:0] = win;
   end

   assign irq_o = win_vld;
   assign rdata = (addr == ADDR_W'(A_STAT)) ? stat : cfg_rdata;

   // R7
   above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (lvl_w[win] > thr));
   // R2
   lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (lvl_w[win] != '0));
   // R9
   src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (win != '0));
   // R6
   en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_CTRL) && !wdata[0]) |=> !irq_o);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   localparam int NS = 64;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = 5'd2;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NS-1:0] irq_in = '1;
   logic          irq_o;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0, cmp_on = 1'b0;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.NUM_BANKS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_in(irq_in), .irq_o(irq_o)
   );

   // behavioural reference model
   int            m_mode [NS];
   int            m_lvl  [NS];
   bit            m_pend [NS];
   bit            m_clr  [NS];
   int            m_thr, m_a;
   bit            m_en, m_rise, m_fall;
   logic [NS-1:0] h1, h2, h3;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            m_mode[s] = 0; m_lvl[s] = 4; m_pend[s] = 0;
         end
         m_thr = 0; m_en = 0; h1 = '1; h2 = '1; h3 = '1;
      end else begin
         m_a = int'(addr);
         for (int s = 0; s < NS; s++) m_clr[s] = 0;
         if (wr_en && (m_a == 4 || m_a == 5))
            for (int h = 0; h < 2; h++)
               if (wdata[16*h+8])
                  m_clr[(m_a-4)*32 + 16*h + int'((wdata >> (16*h)) & 32'hF)] = 1;
         for (int s = 0; s < NS; s++) begin
            m_rise = h2[s] && !h3[s];
            m_fall = !h2[s] && h3[s];
            if (m_mode[s] >= 2)
               m_pend[s] = (m_pend[s] && !m_clr[s]) || ((m_mode[s] == 3) ? m_rise : m_fall);
            else
               m_pend[s] = (m_mode[s] == 1) ? h2[s] : !h2[s];
         end
         if (wr_en) begin
            if (m_a == 0) m_en = wdata[0];
            else if (m_a == 1) m_thr = int'(wdata[7:0]);
            else if (m_a >= 8 && m_a < 12)
               for (int f = 0; f < 16; f++)
                  m_mode[((m_a-8)/2)*32 + (f/8)*16 + ((m_a-8)%2)*8 + f%8]
                     = int'((wdata >> (2*f)) & 32'h3);
            else if (m_a >= 16)
               for (int j = 0; j < 4; j++)
                  m_lvl[((m_a-16)/8)*32 + (j/2)*16 + ((m_a-16)%8)*2 + j%2]
                     = int'((wdata >> (8*j)) & 32'hFF);
         end
         h3 = h2; h2 = h1; h1 = irq_in;
      end
   end

   function automatic logic [31:0] exp_stat();
      int best = 0, win = -1;
      for (int s = 1; s < NS; s++)
         if (m_en && m_pend[s] && m_lvl[s] != 0 && m_lvl[s] > m_thr && m_lvl[s] > best) begin
            best = m_lvl[s];
            win  = s;
         end
      return (win < 0) ? 32'h0001_0000 : 32'(win);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model, away from the edge
   always @(posedge clk) begin
      #3;
      if (cmp_on && !done) begin
         chk("R12", "irq_o vs model", 32'(irq_o),
             (exp_stat() == 32'h0001_0000) ? 32'd0 : 32'd1);
         if (!wr_en && addr == 5'd2)
            chk("R8", "status vs model", rdata, exp_stat());
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 5'd2; wdata = '0;
   endtask

   task automatic rd_chk(input string req, input string what,
                         input int a, input logic [31:0] exp);
      addr = AW'(a);
      #1;
      chk(req, what, rdata, exp);
      addr = 5'd2;
   endtask

   task automatic st_chk(input string req, input string what, input logic [31:0] exp);
      #1;
      chk(req, {what, " status"}, rdata, exp);
      chk(req, {what, " irq_o"}, 32'(irq_o), (exp == 32'h0001_0000) ? 32'd0 : 32'd1);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R12 watchdog: actual timeout expected finish");
         report();
         $finish;
      end
   end

   initial begin
      irq_in = '1;
      irq_in[0] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R13 reset state
      rd_chk("R13", "ctrl after reset", 0, 32'h0);
      rd_chk("R13", "threshold after reset", 1, 32'h0);
      rd_chk("R13", "level word after reset", 16, 32'h0404_0404);
      rd_chk("R13", "mode word after reset", 8, 32'h0);
      st_chk("R13", "after reset", 32'h0001_0000);

      wr(0, 32'h1);
      tick(4);
      st_chk("R9", "source 0 held active", 32'h0001_0000);

      irq_in[5] = 1'b0;
      tick(2);
      st_chk("R12", "two edges after input", 32'h0001_0000);
      tick(1);
      st_chk("R1", "active-low level src5", 32'd5);

      wr(1, 32'd4);
      st_chk("R7", "level equal threshold", 32'h0001_0000);
      wr(1, 32'd3);
      st_chk("R7", "level above threshold", 32'd5);
      wr(1, 32'd0);

      wr(18, 32'h0404_0004);
      st_chk("R2", "level zero src5", 32'h0001_0000);
      rd_chk("R3", "level word 2 readback", 18, 32'h0404_0004);
      rd_chk("R3", "neighbour word untouched", 16, 32'h0404_0404);

      wr(18, 32'h0604_0404);
      irq_in[21] = 1'b0;
      tick(3);
      st_chk("R10", "higher level src21 wins", 32'd21);
      wr(18, 32'h0404_0404);
      st_chk("R10", "tie goes to lowest src5", 32'd5);

      wr(28, 32'h0404_0407);
      irq_in[40] = 1'b0;
      tick(3);
      st_chk("R3", "bank1 lane0 src40 level7", 32'd40);

      irq_in = '1;
      irq_in[0] = 1'b0;
      tick(3);
      st_chk("R11", "level sources released", 32'h0001_0000);

      wr(10, 32'h0000_0C00);
      rd_chk("R4", "mode word bank1 readback", 10, 32'h0000_0C00);
      irq_in[37] = 1'b0;
      tick(4);
      st_chk("R1", "falling input on rising mode", 32'h0001_0000);
      irq_in[37] = 1'b1;
      tick(3);
      st_chk("R1", "rising edge src37", 32'd37);
      irq_in[37] = 1'b0;
      tick(4);
      st_chk("R11", "edge stays latched", 32'd37);
      wr(5, 32'h0000_0005);
      st_chk("R5", "clear without enable bit", 32'd37);
      wr(5, 32'h0105_0000);
      st_chk("R5", "clear of upper half index", 32'd37);
      wr(4, 32'h0000_0105);
      st_chk("R5", "clear sent to other bank", 32'd37);
      wr(5, 32'h0000_0105);
      st_chk("R5", "clear src37", 32'h0001_0000);

      wr(9, 32'h2000_0000);
      rd_chk("R4", "mode word upper field readback", 9, 32'h2000_0000);
      irq_in[30] = 1'b0;
      tick(3);
      st_chk("R1", "falling edge src30", 32'd30);
      wr(4, 32'h010E_0000);
      st_chk("R5", "upper half clear src30", 32'h0001_0000);

      wr(8, 32'h0000_0010);
      tick(2);
      st_chk("R1", "active-high level src2", 32'd2);

      wr(0, 32'h0);
      st_chk("R6", "global enable off", 32'h0001_0000);
      wr(0, 32'h1);
      st_chk("R6", "global enable back on", 32'd2);
      rd_chk("R8", "status word format", 2, 32'd2);

      tick(2);
      done = 1'b1;
      report();
      $finish;
   end
endmodule